// File: doc/BRIEF.md
# Stack Machine Register and ALU Datapath

This block holds the working registers of a 24-bit dual-stack processor: the accumulator T, the data-stack top S, the return-stack top R, the address register A and a carry flag. Behind S sits a circular buffer of 15 entries, so the data stack is 17 deep counting T. Behind R sits a circular buffer of 32 entries, so the return stack is 33 deep counting R. T joins the two stacks into one shift path. PUSH moves a word from the data side to the return side, and POP moves it back.

A sequencer outside this block decodes each non-I/O slot into a 5-bit opcode and raises `exec_i` for one cycle. On that clock edge the datapath applies the stack moves, the ALU result, the memory data and any change to A. Memory reads come in on `rdata_i`. Memory writes use `a_o` as the address and `t_o` as the data, qualified by `mem_wr_o`. The zero flags for T and R feed the branch and loop logic of the sequencer.

Top module: `stack_alu_dp`

## Requirements
- R1: After reset, T, S, R, A and carry are 0 and both circular pointers are at their start. Every entry of both buffers reads 0, and `t_zero_o` and `r_zero_o` are 1.
- R2: While `exec_i` is 0, T, S, R, A and carry hold their values, whatever `op_i` and `rdata_i` are.
- R3: The data buffer behind S holds 15 words and is circular. A push past 15 overwrites the oldest word. A pop with nothing left wraps around and returns the words again instead of signalling an error.
- R4: PUSH (1Ch) moves T into R, pushes the old R onto the 32-word return buffer and pops S into T. POP (18h) moves R into T, pushes the old T onto the data stack and pops the return buffer into R. The return buffer is circular like the data buffer.
- R5: ADD (17h) sets T to (S+T) mod 2^24 and carry to the unsigned carry-out, and pops S. SHL (11h) sets carry to the old T[23] and shifts T left, filling bit 0 with 0. No other opcode changes carry.
- R6: OR (0Eh), XOR (14h) and AND (15h) pop S and combine it into T. COM (10h) inverts T. SHR (12h) shifts T right and keeps bit 23. RR8 (08h) rotates T right by 8, so T[7:0] moves to T[23:16].
- R7: MUL (13h) forms a 25-bit value: S+T when A[0] is 1, or {0,T} otherwise. That value goes through the 48-bit pair T:A shifted right by one: T takes bits 24..1 and A takes {bit 0, A[23:1]}. S is not popped.
- R8: DUP (1Ah) pushes a copy of T. DROP (1Fh) pops S into T. OVER (1Bh) gives n1 n2 -> n1 n2 n1. NIP (0Ch) pops S and keeps T.
- R9: STA (1Dh) copies T into A and pops S into T. LDA (19h) pushes T and loads A into T.
- R10: LD (0Bh), LDP (09h) and LDI (0Ah) push `rdata_i` into T. ST (0Fh) and STP (0Dh) raise `mem_wr_o` combinationally in their execute cycle, with `t_o` as the data and `a_o` as the address, and then pop T. LDP and STP increment A by 1 after the access. The other three leave A unchanged.
- R11: Codes 00h to 07h (the transfer codes), DIV (16h) and NOP (1Eh) leave all state unchanged.
- R12: `t_zero_o` is 1 exactly when T is 0, and `r_zero_o` is 1 exactly when R is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exec_i | input | 1 | Execute strobe for `op_i` |
| op_i | input | 5 | Decoded non-I/O opcode |
| rdata_i | input | 24 | Memory or literal read data |
| t_o | output | 24 | T register, also the write data |
| s_o | output | 24 | S register |
| r_o | output | 24 | R register |
| a_o | output | 24 | A register, used as the memory address |
| carry_o | output | 1 | Carry flag |
| mem_wr_o | output | 1 | Store strobe |
| t_zero_o | output | 1 | T equals 0 |
| r_zero_o | output | 1 | R equals 0 |

## Verification
The hardest state to reach is the wrap point of the data buffer. Only S is visible at the ports, so a wrap shows up only after the stack has been filled past 17 words and then drained past its bottom. The bench loads 17 known literals and drops 16 times. The last drop must bring word 15 back into S. A long run of random opcodes, checked against a behavioural model of both circular buffers, then carries the pointers around both buffers many times while mixing pushes from every direction.

// File: rtl/stack_dp_pkg.sv
package stack_dp_pkg;
  typedef enum logic [4:0] {
    OP_JUMP = 5'h00, OP_RET  = 5'h01, OP_JZ   = 5'h02, OP_JNC  = 5'h03,
    OP_CALL = 5'h04, OP_NEXT = 5'h05, OP_TIMS = 5'h06, OP_RTI  = 5'h07,
    OP_RR8  = 5'h08, OP_LDP  = 5'h09, OP_LDI  = 5'h0A, OP_LD   = 5'h0B,
    OP_NIP  = 5'h0C, OP_STP  = 5'h0D, OP_OR   = 5'h0E, OP_ST   = 5'h0F,
    OP_COM  = 5'h10, OP_SHL  = 5'h11, OP_SHR  = 5'h12, OP_MUL  = 5'h13,
    OP_XOR  = 5'h14, OP_AND  = 5'h15, OP_DIV  = 5'h16, OP_ADD  = 5'h17,
    OP_POP  = 5'h18, OP_LDA  = 5'h19, OP_DUP  = 5'h1A, OP_OVER = 5'h1B,
    OP_PUSH = 5'h1C, OP_STA  = 5'h1D, OP_NOP  = 5'h1E, OP_DROP = 5'h1F
  } op_e;
endpackage

// File: rtl/circ_stack.sv
module circ_stack #(
  parameter int WIDTH = 24,
  parameter int DEPTH = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [WIDTH-1:0] din_i,
  output logic [WIDTH-1:0] top_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] sp_q, sp_inc, sp_dec;

  assign sp_inc = (sp_q == LAST) ? '0 : sp_q + 1'b1;
  assign sp_dec = (sp_q == '0) ? LAST : sp_q - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (push_i) begin
      sp_q          <= sp_inc;
      mem_q[sp_inc] <= din_i;
    end else if (pop_i) begin
      sp_q <= sp_dec;
    end
  end

  assign top_o = mem_q[sp_q];

  // R3
  push_pop_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && pop_i));

  // R3
  ptr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_q <= LAST);

  // R3
  push_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> top_o == $past(din_i));
endmodule

// File: rtl/stack_alu.sv
module stack_alu
  import stack_dp_pkg::*;
#(
  parameter int W = 24
) (
  input  op_e          op_i,
  input  logic [W-1:0] t_i,
  input  logic [W-1:0] s_i,
  input  logic [W-1:0] a_i,
  input  logic         c_i,
  output logic [W-1:0] t_o,
  output logic [W-1:0] a_o,
  output logic         c_o
);
  logic [W:0] sum, mul_sum;

  assign sum     = {1'b0, s_i} + {1'b0, t_i};
  assign mul_sum = a_i[0] ? sum : {1'b0, t_i};

  always_comb begin
    t_o = t_i;
    a_o = a_i;
    c_o = c_i;
    unique case (op_i)
      OP_OR:   t_o = t_i | s_i;
      OP_XOR:  t_o = t_i ^ s_i;
      OP_AND:  t_o = t_i & s_i;
      OP_ADD:  {c_o, t_o} = sum;
      OP_COM:  t_o = ~t_i;
      OP_SHL:  begin c_o = t_i[W-1]; t_o = {t_i[W-2:0], 1'b0}; end
      OP_SHR:  t_o = {t_i[W-1], t_i[W-1:1]};
      OP_RR8:  t_o = {t_i[7:0], t_i[W-1:8]};
      OP_MUL:  begin t_o = mul_sum[W:1]; a_o = {mul_sum[0], a_i[W-1:1]}; end
      default: ;
    endcase
  end
endmodule

// File: rtl/stack_alu_dp.sv
module stack_alu_dp
  import stack_dp_pkg::*;
#(
  parameter int DATA_W   = 24,
  parameter int DS_DEPTH = 17,
  parameter int RS_DEPTH = 33
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              exec_i,
  input  logic [4:0]        op_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] t_o,
  output logic [DATA_W-1:0] s_o,
  output logic [DATA_W-1:0] r_o,
  output logic [DATA_W-1:0] a_o,
  output logic              carry_o,
  output logic              mem_wr_o,
  output logic              t_zero_o,
  output logic              r_zero_o
);
  localparam int DS_MEM = DS_DEPTH - 2;  // T and S are registers
  localparam int RS_MEM = RS_DEPTH - 1;  // R is a register

  op_e op;
  assign op = op_e'(op_i);

  logic [DATA_W-1:0] t_q, s_q, r_q, a_q, t_d, s_d, r_d, a_d;
  logic              c_q, c_d;
  logic [DATA_W-1:0] ds_top, rs_top, alu_t, alu_a;
  logic              alu_c;
  logic              ds_push, ds_pop, rs_push, rs_pop;

  stack_alu #(.W(DATA_W)) u_alu (
    .op_i(op), .t_i(t_q), .s_i(s_q), .a_i(a_q), .c_i(c_q),
    .t_o(alu_t), .a_o(alu_a), .c_o(alu_c)
  );

  circ_stack #(.WIDTH(DATA_W), .DEPTH(DS_MEM)) u_dstk (
    .clk_i, .rst_ni, .push_i(ds_push), .pop_i(ds_pop), .din_i(s_q), .top_o(ds_top)
  );

  circ_stack #(.WIDTH(DATA_W), .DEPTH(RS_MEM)) u_rstk (
    .clk_i, .rst_ni, .push_i(rs_push), .pop_i(rs_pop), .din_i(r_q), .top_o(rs_top)
  );

  always_comb begin
    t_d = t_q; s_d = s_q; r_d = r_q; a_d = a_q; c_d = c_q;
    ds_push = 1'b0; ds_pop = 1'b0; rs_push = 1'b0; rs_pop = 1'b0;
    if (exec_i) begin
      unique case (op)
        OP_OR, OP_XOR, OP_AND, OP_ADD: begin
          t_d = alu_t; c_d = alu_c; s_d = ds_top; ds_pop = 1'b1;
        end
        OP_COM, OP_SHL, OP_SHR, OP_RR8: begin
          t_d = alu_t; c_d = alu_c;
        end
        OP_MUL: begin t_d = alu_t; a_d = alu_a; end
        OP_NIP: begin s_d = ds_top; ds_pop = 1'b1; end
        OP_DROP: begin t_d = s_q; s_d = ds_top; ds_pop = 1'b1; end
        OP_DUP: begin s_d = t_q; ds_push = 1'b1; end
        OP_OVER: begin t_d = s_q; s_d = t_q; ds_push = 1'b1; end
        OP_STA: begin a_d = t_q; t_d = s_q; s_d = ds_top; ds_pop = 1'b1; end
        OP_LDA: begin t_d = a_q; s_d = t_q; ds_push = 1'b1; end
        OP_PUSH: begin
          r_d = t_q; rs_push = 1'b1; t_d = s_q; s_d = ds_top; ds_pop = 1'b1;
        end
        OP_POP: begin
          t_d = r_q; r_d = rs_top; rs_pop = 1'b1; s_d = t_q; ds_push = 1'b1;
        end
        OP_LD, OP_LDI, OP_LDP: begin
          t_d = rdata_i; s_d = t_q; ds_push = 1'b1;
          if (op == OP_LDP) a_d = a_q + 1'b1;
        end
        OP_ST, OP_STP: begin
          t_d = s_q; s_d = ds_top; ds_pop = 1'b1;
          if (op == OP_STP) a_d = a_q + 1'b1;
        end
        default: ;  // transfer codes, DIV, NOP
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t_q <= '0; s_q <= '0; r_q <= '0; a_q <= '0; c_q <= 1'b0;
    end else begin
      t_q <= t_d; s_q <= s_d; r_q <= r_d; a_q <= a_d; c_q <= c_d;
    end
  end

  assign t_o      = t_q;
  assign s_o      = s_q;
  assign r_o      = r_q;
  assign a_o      = a_q;
  assign carry_o  = c_q;
  assign mem_wr_o = exec_i && (op == OP_ST || op == OP_STP);
  assign t_zero_o = (t_q == '0);
  assign r_zero_o = (r_q == '0);

  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_i |=> $stable(t_q) && $stable(s_q) && $stable(r_q) && $stable(a_q) && $stable(c_q));

  // R5
  carry_only_alu_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(exec_i && (op == OP_ADD || op == OP_SHL)) |=> $stable(c_q));

  // R4
  push_to_r_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && op == OP_PUSH) |=> r_q == $past(t_q));

  // R9
  sta_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && op == OP_STA) |=> a_q == $past(t_q));

  // R10
  ldp_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && op == OP_LDP) |=> a_q == $past(a_q) + 1'b1);

  // R7
  mul_skip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && op == OP_MUL && !a_q[0]) |=> t_q == ($past(t_q) >> 1));
endmodule

// File: tb/stack_alu_dp_tb.sv
`timescale 1ns/1ps
module stack_alu_dp_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exec = 1'b0;
  logic [4:0]  op = 5'h1E;
  logic [23:0] rdata = '0;
  logic [23:0] t_o, s_o, r_o, a_o;
  logic        carry_o, mem_wr_o, t_zero_o, r_zero_o;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  stack_alu_dp u_dut (
    .clk_i(clk), .rst_ni(rst_n), .exec_i(exec), .op_i(op), .rdata_i(rdata),
    .t_o(t_o), .s_o(s_o), .r_o(r_o), .a_o(a_o), .carry_o(carry_o),
    .mem_wr_o(mem_wr_o), .t_zero_o(t_zero_o), .r_zero_o(r_zero_o)
  );

  // behavioural model
  logic [23:0] mt, ms, mr, ma;
  logic        mc;
  logic [23:0] mds [15];
  logic [23:0] mrs [32];
  int          mdsp, mrsp;

  function automatic void dpush(logic [23:0] v);
    mdsp = (mdsp == 14) ? 0 : mdsp + 1;
    mds[mdsp] = v;
  endfunction
  function automatic logic [23:0] dpop();
    logic [23:0] v = mds[mdsp];
    mdsp = (mdsp == 0) ? 14 : mdsp - 1;
    return v;
  endfunction
  function automatic void rpush(logic [23:0] v);
    mrsp = (mrsp == 31) ? 0 : mrsp + 1;
    mrs[mrsp] = v;
  endfunction
  function automatic logic [23:0] rpop();
    logic [23:0] v = mrs[mrsp];
    mrsp = (mrsp == 0) ? 31 : mrsp - 1;
    return v;
  endfunction

  function automatic void m_reset();
    mt = 0; ms = 0; mr = 0; ma = 0; mc = 0; mdsp = 0; mrsp = 0;
    for (int i = 0; i < 15; i++) mds[i] = 0;
    for (int i = 0; i < 32; i++) mrs[i] = 0;
  endfunction

  function automatic void m_step(logic [4:0] o, logic [23:0] rd);
    logic [24:0] sm;
    logic [23:0] tmp;
    case (o)
      5'h0E: begin mt = mt | ms; ms = dpop(); end
      5'h14: begin mt = mt ^ ms; ms = dpop(); end
      5'h15: begin mt = mt & ms; ms = dpop(); end
      5'h17: begin sm = {1'b0, ms} + {1'b0, mt}; mc = sm[24]; mt = sm[23:0]; ms = dpop(); end
      5'h10: mt = ~mt;
      5'h11: begin mc = mt[23]; mt = mt << 1; end
      5'h12: mt = {mt[23], mt[23:1]};
      5'h08: mt = {mt[7:0], mt[23:8]};
      5'h13: begin
        sm = ma[0] ? ({1'b0, ms} + {1'b0, mt}) : {1'b0, mt};
        ma = {sm[0], ma[23:1]}; mt = sm[24:1];
      end
      5'h1A: begin dpush(ms); ms = mt; end
      5'h1F: begin mt = ms; ms = dpop(); end
      5'h1B: begin tmp = ms; dpush(ms); ms = mt; mt = tmp; end
      5'h0C: ms = dpop();
      5'h1D: begin ma = mt; mt = ms; ms = dpop(); end
      5'h19: begin dpush(ms); ms = mt; mt = ma; end
      5'h1C: begin rpush(mr); mr = mt; mt = ms; ms = dpop(); end
      5'h18: begin dpush(ms); ms = mt; mt = mr; mr = rpop(); end
      5'h0B, 5'h0A, 5'h09: begin dpush(ms); ms = mt; mt = rd; if (o == 5'h09) ma = ma + 1; end
      5'h0F, 5'h0D: begin mt = ms; ms = dpop(); if (o == 5'h0D) ma = ma + 1; end
      default: ;
    endcase
  endfunction

  function automatic string req_of(logic [4:0] o);
    case (o)
      5'h17, 5'h11: return "R5";
      5'h0E, 5'h14, 5'h15, 5'h10, 5'h12, 5'h08: return "R6";
      5'h13: return "R7";
      5'h1A, 5'h1F, 5'h1B, 5'h0C: return "R8";
      5'h1D, 5'h19: return "R9";
      5'h1C, 5'h18: return "R4";
      5'h0B, 5'h0A, 5'h09, 5'h0F, 5'h0D: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic cmp_all(string tag);
    chk(tag, "T", t_o, mt);
    chk(tag, "S", s_o, ms);
    chk(tag, "R", r_o, mr);
    chk(tag, "A", a_o, ma);
    chk(tag, "carry", {23'd0, carry_o}, {23'd0, mc});
    chk("R12", "t_zero", {23'd0, t_zero_o}, {23'd0, mt == 0});
    chk("R12", "r_zero", {23'd0, r_zero_o}, {23'd0, mr == 0});
  endtask

  // called at a negedge; returns at the next negedge
  task automatic do_op(logic e, logic [4:0] o, logic [23:0] rd);
    string tag;
    exec = e; op = o; rdata = rd;
    tag = e ? req_of(o) : "R2";
    #1;
    chk("R10", "mem_wr", {23'd0, mem_wr_o}, {23'd0, e && (o == 5'h0F || o == 5'h0D)});
    @(posedge clk);
    if (e) m_step(o, rd);
    @(negedge clk);
    exec = 1'b0;
    cmp_all(tag);
  endtask

  task automatic ld(logic [23:0] v);
    do_op(1'b1, 5'h0B, v);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; exec = 1'b0;
    m_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    cmp_all("R1");

    // R3 wrap: 17 literals then 16 drops; last drop returns word 15 into S
    for (int i = 1; i <= 17; i++) ld(24'(i));
    for (int i = 1; i <= 16; i++) do_op(1'b1, 5'h1F, 0);
    chk("R3", "T after wrap", t_o, 24'd1);
    chk("R3", "S after wrap", s_o, 24'd15);

    // R5 ADD carry-out
    do_reset();
    ld(24'hFFFFFF); ld(24'h000002);
    do_op(1'b1, 5'h17, 0);
    chk("R5", "ADD sum", t_o, 24'h000001);
    chk("R5", "ADD carry", {23'd0, carry_o}, 24'd1);
    // R5 SHL takes old bit 23
    ld(24'h400001);
    do_op(1'b1, 5'h11, 0);
    chk("R5", "SHL T", t_o, 24'h800002);
    chk("R5", "SHL carry", {23'd0, carry_o}, 24'd0);

    // R6 SHR keeps sign, RR8 rotates
    ld(24'h800010);
    do_op(1'b1, 5'h12, 0);
    chk("R6", "SHR", t_o, 24'hC00008);
    ld(24'h123456);
    do_op(1'b1, 5'h08, 0);
    chk("R6", "RR8", t_o, 24'h561234);

    // R7 MUL add step: A=5, S=3, T=10h
    do_reset();
    ld(24'd5); do_op(1'b1, 5'h1D, 0);
    ld(24'd3); ld(24'h10);
    do_op(1'b1, 5'h13, 0);
    chk("R7", "MUL T", t_o, 24'h000009);
    chk("R7", "MUL A", a_o, 24'h800002);
    chk("R7", "MUL S kept", s_o, 24'd3);

    // R4 PUSH/POP round trip
    ld(24'hABCDEF);
    do_op(1'b1, 5'h1C, 0);
    chk("R4", "PUSH R", r_o, 24'hABCDEF);
    do_op(1'b1, 5'h18, 0);
    chk("R4", "POP T", t_o, 24'hABCDEF);
    chk("R12", "r_zero after POP", {23'd0, r_zero_o}, 24'd1);

    // R10 STP strobe and increment
    ld(24'h000100); do_op(1'b1, 5'h1D, 0);
    do_op(1'b1, 5'h0D, 0);
    chk("R10", "STP A", a_o, 24'h000101);

    // R11 no-op codes, R2 idle sweep with every opcode
    for (int o = 0; o < 32; o++) begin
      if (o <= 7 || o == 5'h16 || o == 5'h1E) do_op(1'b1, 5'(o), 24'h5A5A5A);
      do_op(1'b0, 5'(o), 24'hA5A5A5);
    end

    // exhaustive opcode sweep under several operand patterns
    for (int p = 0; p < 6; p++) begin
      for (int o = 0; o < 32; o++) begin
        ld(24'(p * 24'h2A5F1 + 1)); ld(24'(24'hFFFFFF - p * 24'h13377));
        do_op(1'b1, 5'(o), 24'(p * 24'h1111));
      end
    end

    // long random run drives both pointers around their buffers
    for (int n = 0; n < 5000; n++) begin
      logic [4:0] o = 5'($urandom_range(0, 31));
      logic [23:0] rd = ($urandom_range(0, 7) == 0) ? 24'd0 : 24'($urandom);
      do_op(($urandom_range(0, 9) != 0), o, rd);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule